// File: doc/BRIEF.md
# Multichannel ADC Conversion Readout

This block runs one conversion cycle of a simultaneous-sampling ADC and hands one signed sample per channel to a downstream filter. The cycle has a fixed sequence. When `start` is seen while the block is idle, it raises the conversion strobe for a fixed number of cycles and then waits out the conversion time. Next it gates the read clock for as many cycles as one lane needs to carry its share of the bits. All lanes shift in parallel.

The ADC's data comes back late by a round-trip latency through the returned clock and data path. The block therefore starts sampling each lane that many cycles after it issues the matching read clock. After the last bit, it loads all samples into the output register at once and pulses `done`.

The samples are presented in reversed channel order. Output slot k carries ADC channel NCH-1-k, which matches the index order the downstream filter uses.

Top module: `mcadc_readout`

## Requirements
- R1: After synchronous reset `busy`, `done`, `adc_cnv` and `adc_sck` are 0 and `samples` is all zero. While idle, neither `adc_cnv` nor `adc_sck` is asserted.
- R2: When `start` is high at a clock edge while `busy` is 0, `adc_cnv` rises in the next cycle and stays high for exactly T_CNVH cycles (default 4). `busy` is 1 from that cycle on.
- R3: After `adc_cnv` falls, both `adc_cnv` and `adc_sck` stay low for exactly T_CONV cycles (default 57). They are never high together.
- R4: `adc_sck` is then high for exactly READ_LEN = NCH*SMP_W/LANES consecutive cycles (default 8*16/8 = 16).
- R5: Bit k of every lane (k = 0 first) is taken from `adc_sdo` in the cycle that lies T_RTT cycles (default 8) after the k-th cycle with `adc_sck` high.
- R6: Lane l carries ADC channels l*CPL to l*CPL+CPL-1, where CPL = NCH/LANES. The channels go in increasing order and each is sent MSB first.
- R7: Output slot k, `samples[k*SMP_W +: SMP_W]`, holds ADC channel NCH-1-k as a 16-bit two's complement word.
- R8: `done` is high for exactly one cycle, T_CNVH+T_CONV+READ_LEN+T_RTT+1 clock edges after the edge that accepted `start` (default 86). `busy` is 0 in that same cycle.
- R9: `start` has no effect while `busy` is 1. A pulse during a cycle neither shortens it nor launches another cycle after `done`.
- R10: `samples` changes only at the edge that raises `done`. It holds its value otherwise, including through the whole of the next conversion cycle.
- R11: If `start` is high in the `done` cycle, the next cycle begins at once: `adc_cnv` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a conversion cycle, honoured only when idle |
| adc_cnv | output | 1 | Conversion strobe to the ADC |
| adc_sck | output | 1 | Read clock enable towards the ADC serial clock |
| adc_sdo | input | LANES | Serial data lanes returned from the ADC |
| busy | output | 1 | A conversion cycle is in progress |
| done | output | 1 | One-cycle pulse: new samples are valid |
| samples | output | NCH*SMP_W | Packed samples, slot k = ADC channel NCH-1-k |

## Verification
The hardest condition to reach is the alignment between issued read clocks and returned data. Data sampled one cycle early or late still gives plausible words, so it hides unless bit patterns expose a shift. The bench models the ADC with a delay line of exactly T_RTT cycles between each read-clock cycle and its data bit. It drives walking-one patterns that are offset per channel, so any bit slip, any lane swap or any break in the reversed ordering changes a known single bit. Pulses on `start` mid-cycle and a `start` held through `done` show that requests are ignored while busy and accepted back to back.

// File: rtl/mcadc_pkg.sv
package mcadc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CNVH,
        PH_CONV,
        PH_READ,
        PH_RTT,
        PH_FIN
    } phase_e;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int read_cycles(input int nch, input int w, input int lanes);
        return (nch * w) / lanes;
    endfunction

endpackage

// File: rtl/mcadc_sequencer.sv
module mcadc_sequencer
    import mcadc_pkg::*;
#(
    parameter int T_CNVH = 4,
    parameter int T_CONV = 57,
    parameter int T_READ = 16,
    parameter int T_RTT  = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase_o
);
    localparam int MAXT  = max_of4(T_CNVH, T_CONV, T_READ, T_RTT);
    localparam int CNT_W = $clog2(MAXT + 1);
    localparam logic [CNT_W-1:0] LD_CNVH = CNT_W'(T_CNVH - 1);
    localparam logic [CNT_W-1:0] LD_CONV = CNT_W'(T_CONV - 1);
    localparam logic [CNT_W-1:0] LD_READ = CNT_W'(T_READ - 1);
    localparam logic [CNT_W-1:0] LD_RTT  = CNT_W'(T_RTT - 1);

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last    = (cnt_q == '0);
    assign phase_o = ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (start) begin
                    ph_q  <= PH_CNVH;
                    cnt_q <= LD_CNVH;
                end
                PH_CNVH: if (last) begin
                    ph_q  <= PH_CONV;
                    cnt_q <= LD_CONV;
                end else cnt_q <= cnt_q - CNT_W'(1);
                PH_CONV: if (last) begin
                    ph_q  <= PH_READ;
                    cnt_q <= LD_READ;
                end else cnt_q <= cnt_q - CNT_W'(1);
                PH_READ: if (last) begin
                    ph_q  <= PH_RTT;
                    cnt_q <= LD_RTT;
                end else cnt_q <= cnt_q - CNT_W'(1);
                PH_RTT: if (last) begin
                    ph_q <= PH_FIN;
                end else cnt_q <= cnt_q - CNT_W'(1);
                PH_FIN:  ph_q <= PH_IDLE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mcadc_lane_capture.sv
module mcadc_lane_capture #(
    parameter int LANES    = 8,
    parameter int READ_LEN = 16,
    parameter int T_RTT    = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd_active,
    input  logic [LANES-1:0]          sdo,
    output logic [LANES*READ_LEN-1:0] lane_bits_o
);
    // Delay the read-clock enable by the round-trip latency.
    logic [T_RTT-1:0] dly_q;
    logic             cap_en;

    generate
        if (T_RTT == 1) begin : g_dly_one
            always_ff @(posedge clk) begin
                if (rst) dly_q <= '0;
                else     dly_q <= rd_active;
            end
        end else begin : g_dly_line
            always_ff @(posedge clk) begin
                if (rst) dly_q <= '0;
                else     dly_q <= {dly_q[T_RTT-2:0], rd_active};
            end
        end
    endgenerate

    assign cap_en = dly_q[T_RTT-1];

    // One shift register per lane; first received bit ends up at the top.
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [READ_LEN-1:0] sh_q;
            always_ff @(posedge clk) begin
                if (rst)         sh_q <= '0;
                else if (cap_en) sh_q <= {sh_q[READ_LEN-2:0], sdo[l]};
            end
            assign lane_bits_o[l*READ_LEN +: READ_LEN] = sh_q;
        end
    endgenerate
endmodule

// File: rtl/mcadc_readout.sv
module mcadc_readout
    import mcadc_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int SMP_W  = 16,
    parameter int LANES  = 8,
    parameter int T_CNVH = 4,
    parameter int T_CONV = 57,
    parameter int T_RTT  = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    output logic                   adc_cnv,
    output logic                   adc_sck,
    input  logic [LANES-1:0]       adc_sdo,
    output logic                   busy,
    output logic                   done,
    output logic [NCH*SMP_W-1:0]   samples
);
    localparam int CPL      = NCH / LANES;
    localparam int READ_LEN = read_cycles(NCH, SMP_W, LANES);

    phase_e                      phase;
    logic [LANES*READ_LEN-1:0]   lane_bits;
    logic [NCH*SMP_W-1:0]        ordered;
    logic [NCH*SMP_W-1:0]        samples_q;
    logic                        done_q;

    mcadc_sequencer #(
        .T_CNVH (T_CNVH),
        .T_CONV (T_CONV),
        .T_READ (READ_LEN),
        .T_RTT  (T_RTT)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .phase_o (phase)
    );

    mcadc_lane_capture #(
        .LANES    (LANES),
        .READ_LEN (READ_LEN),
        .T_RTT    (T_RTT)
    ) cap_i (
        .clk         (clk),
        .rst         (rst),
        .rd_active   (phase == PH_READ),
        .sdo         (adc_sdo),
        .lane_bits_o (lane_bits)
    );

    // Slot k takes ADC channel NCH-1-k from its lane position.
    generate
        for (genvar k = 0; k < NCH; k++) begin : g_slot
            localparam int CH  = NCH - 1 - k;
            localparam int LN  = CH / CPL;
            localparam int POS = CH % CPL;
            assign ordered[k*SMP_W +: SMP_W] =
                lane_bits[LN*READ_LEN + READ_LEN - 1 - POS*SMP_W -: SMP_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q    <= 1'b0;
            samples_q <= '0;
        end else begin
            done_q <= (phase == PH_FIN);
            if (phase == PH_FIN) samples_q <= ordered;
        end
    end

    assign adc_cnv = (phase == PH_CNVH);
    assign adc_sck = (phase == PH_READ);
    assign busy    = (phase != PH_IDLE);
    assign done    = done_q;
    assign samples = samples_q;
endmodule

// File: rtl/mcadc_readout_chk.sv
module mcadc_readout_chk #(
    parameter int T_CNVH    = 4,
    parameter int READ_LEN  = 16,
    parameter int SAMP_BITS = 128
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 adc_cnv,
    input logic                 adc_sck,
    input logic                 busy,
    input logic                 done,
    input logic [SAMP_BITS-1:0] samples
);
    logic [15:0] cnv_run;
    logic [15:0] sck_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnv_run <= '0;
            sck_run <= '0;
        end else begin
            cnv_run <= adc_cnv ? cnv_run + 16'd1 : 16'd0;
            sck_run <= adc_sck ? sck_run + 16'd1 : 16'd0;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!adc_cnv && !adc_sck)); // R1
    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (adc_cnv && busy)); // R2
    AST_CNVH_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cnv) |-> (cnv_run == 16'(T_CNVH))); // R2
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(adc_cnv && adc_sck)); // R3
    AST_SCK_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_sck) |-> (sck_run == 16'(READ_LEN))); // R4
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (busy && !adc_cnv) |=> !$rose(adc_cnv)); // R9
    AST_HOLD_SAMPLES: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(samples)); // R10
endmodule

bind mcadc_readout mcadc_readout_chk #(
    .T_CNVH    (T_CNVH),
    .READ_LEN  (READ_LEN),
    .SAMP_BITS (NCH*SMP_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .adc_cnv (adc_cnv),
    .adc_sck (adc_sck),
    .busy    (busy),
    .done    (done),
    .samples (samples)
);

// File: tb/mcadc_readout_tb.sv
module mcadc_readout_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH    = 8;
    localparam int W      = 16;
    localparam int LANES  = 8;
    localparam int T_CNVH = 4;
    localparam int T_CONV = 57;
    localparam int T_RTT  = 8;
    localparam int CPL    = NCH / LANES;
    localparam int RLEN   = NCH * W / LANES;
    localparam int DONE_T = T_CNVH + T_CONV + RLEN + T_RTT + 2; // negedge index of done

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic                 adc_cnv, adc_sck, busy, done;
    logic [LANES-1:0]     adc_sdo = '0;
    logic [NCH*W-1:0]     samples;
    logic [NCH*W-1:0]     chan_vals = '0;   // indexed by ADC channel
    logic [NCH*W-1:0]     last_exp = '0;    // expected samples after last done

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcadc_readout #(
        .NCH(NCH), .SMP_W(W), .LANES(LANES),
        .T_CNVH(T_CNVH), .T_CONV(T_CONV), .T_RTT(T_RTT)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .adc_cnv(adc_cnv), .adc_sck(adc_sck), .adc_sdo(adc_sdo),
        .busy(busy), .done(done), .samples(samples)
    );

    // ADC model: data for read-clock cycle k appears T_RTT cycles later.
    int idx_line [T_RTT+1];
    int seen = 0;
    initial for (int j = 0; j <= T_RTT; j++) idx_line[j] = -1;

    always @(negedge clk) begin
        for (int j = T_RTT; j > 0; j--) idx_line[j] = idx_line[j-1];
        if (adc_cnv) seen = 0;
        if (adc_sck) begin
            idx_line[0] = seen;
            seen++;
        end else idx_line[0] = -1;
        for (int l = 0; l < LANES; l++) begin
            if (idx_line[T_RTT] >= 0) begin
                int ch;
                int bt;
                ch = l*CPL + idx_line[T_RTT] / W;
                bt = W - 1 - (idx_line[T_RTT] % W);
                adc_sdo[l] = chan_vals[ch*W + bt];
            end else adc_sdo[l] = 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NCH*W-1:0] reversed_of(input logic [NCH*W-1:0] v);
        logic [NCH*W-1:0] r;
        for (int k = 0; k < NCH; k++) r[k*W +: W] = v[(NCH-1-k)*W +: W];
        return r;
    endfunction

    // One conversion: poke = pulse start mid-cycle, hold = keep start high through done.
    task automatic run_conv(input logic [NCH*W-1:0] vals, input bit poke, input bit hold);
        int t_cnv_first = -1, cnv_cnt = 0, t_sck_first = -1, sck_cnt = 0;
        int t_done = -1, done_cnt = 0, gap_bad = 0;
        logic [NCH*W-1:0] prev_exp;
        logic [NCH*W-1:0] exp_s;
        prev_exp = last_exp;
        exp_s    = reversed_of(vals);
        @(negedge clk);
        chan_vals = vals;
        start = 1'b1;
        for (int t = 1; t <= DONE_T + 3; t++) begin
            @(negedge clk);
            if (t == 1 && !hold) start = 1'b0;
            if (poke && t == 30) start = 1'b1;
            if (poke && t == 31) start = 1'b0;
            if (adc_cnv && t <= DONE_T) begin
                if (t_cnv_first < 0) t_cnv_first = t;
                cnv_cnt++;
            end
            if (adc_sck) begin
                if (t_sck_first < 0) t_sck_first = t;
                sck_cnt++;
            end
            if (t > T_CNVH && t <= T_CNVH + T_CONV && (adc_cnv || adc_sck)) gap_bad++;
            if (t == 40)
                check(samples == prev_exp, "R10 samples held during next cycle",
                      longint'(samples[63:0]), longint'(prev_exp[63:0]));
            if (done) begin
                if (t_done < 0) begin
                    t_done = t;
                    check(!busy, "R8 busy low with done", busy, 0);
                end
                done_cnt++;
            end
            if (hold && t == DONE_T + 1) begin
                check(adc_cnv == 1'b1, "R11 back-to-back launch", adc_cnv, 1);
                start = 1'b0;
            end
        end
        check(t_cnv_first == 1, "R2 strobe rises after start", t_cnv_first, 1);
        check(cnv_cnt == T_CNVH, "R2 strobe length", cnv_cnt, T_CNVH);
        check(gap_bad == 0, "R3 conversion wait quiet", gap_bad, 0);
        check(t_sck_first == T_CNVH + T_CONV + 1, "R3 read start after wait",
              t_sck_first, T_CNVH + T_CONV + 1);
        check(sck_cnt == RLEN, "R4 read length", sck_cnt, RLEN);
        check(t_done == DONE_T, "R8 done timing", t_done, DONE_T);
        check(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
        if (poke) check(!busy && !adc_cnv, "R9 start while busy ignored", busy, 0);
        for (int k = 0; k < NCH; k++)
            check(samples[k*W +: W] == exp_s[k*W +: W], "R5 R6 R7 sample slot value",
                  longint'(samples[k*W +: W]), longint'(exp_s[k*W +: W]));
        last_exp = exp_s;
        if (hold) begin
            // the relaunched cycle uses the same values; let it finish
            while (!done) @(negedge clk);
            last_exp = exp_s;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [NCH*W-1:0] v;
        logic [31:0]      seed;
        seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({adc_cnv, adc_sck, busy, done} == 4'b0, "R1 reset outputs quiet",
              {adc_cnv, adc_sck, busy, done}, 0);
        check(samples == '0, "R1 reset samples zero", longint'(samples[63:0]), 0);
        repeat (5) @(negedge clk);
        check(!adc_cnv && !adc_sck, "R1 idle without start", adc_cnv, 0);

        // extreme values
        run_conv('0, 1'b0, 1'b0);
        run_conv('1, 1'b0, 1'b0);
        for (int c = 0; c < NCH; c++) v[c*W +: W] = (c % 2) ? 16'h8000 : 16'h7FFF;
        run_conv(v, 1'b0, 1'b0);
        // distinct per-channel values reveal ordering
        for (int c = 0; c < NCH; c++) v[c*W +: W] = 16'(c * 16'h1111 + 16'h0A05);
        run_conv(v, 1'b1, 1'b0);
        // walking one, offset per channel
        for (int b = 0; b < W; b++) begin
            for (int c = 0; c < NCH; c++) v[c*W +: W] = 16'(1 << ((b + c) % W));
            run_conv(v, 1'b0, 1'b0);
        end
        // pseudo-random values, one run with start held through done
        for (int r = 0; r < 10; r++) begin
            for (int c = 0; c < NCH; c++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                v[c*W +: W] = seed[31:16];
            end
            run_conv(v, (r == 3), (r == 6));
        end
        finish_run();
    end
endmodule